// File: doc/BRIEF.md
# Fast Ethernet transmit line coder

This block turns the transmit data of a 100 Mb/s Ethernet MAC into the ternary symbol stream sent to the line driver. It runs on a single clock at the 125 Mb/s bit rate. It counts five bit periods per code group and drives a sample strobe that tells the MAC when to present data. When `rmii_mode` is low, each strobe takes a 4-bit nibble. When it is high, each strobe takes a 2-bit dibit, and two dibits make a nibble. The mode input is static and may change only while reset is held.

Each nibble becomes a 5-bit code group. A frame opens with a start-of-stream delimiter pair, which replaces the first two nibbles, and closes with an end-of-stream pair. IDLE groups fill the line between frames. The group bits are scrambled and sent one per clock. They are then NRZI-coded and finally mapped to a three-level MLT-3 output.

Top module: `fetx_coder`

## Requirements
- R1: While `rst_n` is low, `line` is 0 and `nrzi_o` is 0. The scrambler state is loaded with `SEED` (default 11'h7FF). The group counter starts at phase 0, and the first group sent after reset is IDLE.
- R2: The phase counts 0..4 once per clock, starting at 0 in the first cycle after reset. With `rmii_mode`=0, `smp` is high only at phase 0. With `rmii_mode`=1, `smp` is high at phases 0 and 3. Inputs are taken at the clock edge that ends a cycle in which `smp` is high.
- R3: In the dibit mode, `txd[1:0]` at phase 0 supplies nibble bits 1:0 and `txd[1:0]` at phase 3 supplies nibble bits 3:2. `txd[3:2]` has no effect. `tx_en` is taken at phase 0 in both modes.
- R4: A data nibble maps to a code group written with bit 4 on the left: 0→11110, 1→01001, 2→10100, 3→10101, 4→01010, 5→01011, 6→01110, 7→01111, 8→10010, 9→10011, A→10110, B→10111, C→11010, D→11011, E→11100, F→11101. Bit 0 of each group is sent first, at phase 0. A nibble taken in one group period is sent in the next.
- R5: When `tx_en` is sampled high after idle, the group J (11000) takes the place of that nibble. The group K (10001) takes the place of the next nibble, whatever `tx_en` is for it.
- R6: The first nibble sampled with `tx_en` low after data is replaced by T (01101). The next group is R (00111), and the nibble sampled in that period is ignored even if `tx_en` is high. IDLE (11111) follows until `tx_en` is sampled high again.
- R7: Every bit sent is XORed with a key k = s[10]^s[8] of an 11-bit shift register s. The register shifts left each clock with k entering at bit 0.
- R8: `nrzi_o` toggles after each clock whose scrambled bit is 1 and holds otherwise.
- R9: `line` (two's complement) steps through 0, +1, 0, -1 and repeats on each scrambled 1 bit, and holds on a 0 bit. It never takes the value -2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rmii_mode | input | 1 | 0: 4-bit input per strobe, 1: 2-bit input per strobe |
| tx_en | input | 1 | Transmit enable from the MAC |
| txd | input | 4 | Transmit data from the MAC |
| smp | output | 1 | Input sample strobe |
| nrzi_o | output | 1 | NRZI-coded serial bit |
| line | output | 2 | Signed MLT-3 line level |

## Verification
The hardest case to reach is a frame whose enable comes back during the single group period in which the end pair is still being sent. That nibble must be lost, and the next one must open a fresh J/K pair. The stimulus reaches it by closing one frame with an enable gap of exactly one nibble period, in both input modes. One-nibble and two-nibble frames are also sent, so that the K and T groups fall on nibbles the MAC marked as idle. Every code group is checked against the bench's model by recovering it from the NRZI output: the bench undoes the NRZI and removes the scrambler key with its own copy of the shift register.

// File: rtl/fetx_coder.sv
module fetx_coder #(
  parameter logic [10:0] SEED = 11'h7FF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rmii_mode,
  input  logic              tx_en,
  input  logic [3:0]        txd,
  output logic              smp,
  output logic              nrzi_o,
  output logic signed [1:0] line
);
  localparam logic [4:0] CG_IDLE = 5'b11111;
  localparam logic [4:0] CG_J    = 5'b11000;
  localparam logic [4:0] CG_K    = 5'b10001;
  localparam logic [4:0] CG_T    = 5'b01101;
  localparam logic [4:0] CG_R    = 5'b00111;

  typedef enum logic [1:0] {F_IDLE, F_K, F_DATA, F_R} frm_t;

  logic [2:0]  bc;
  logic [3:0]  nib;
  logic        en_s;
  frm_t        st, st_n;
  logic [4:0]  sh, nxt;
  logic [10:0] lf;
  logic [1:0]  lvl;
  logic        key, sbit, last;

  function automatic logic [4:0] enc(input logic [3:0] n);
    case (n)
      4'h0: enc = 5'b11110;  4'h1: enc = 5'b01001;
      4'h2: enc = 5'b10100;  4'h3: enc = 5'b10101;
      4'h4: enc = 5'b01010;  4'h5: enc = 5'b01011;
      4'h6: enc = 5'b01110;  4'h7: enc = 5'b01111;
      4'h8: enc = 5'b10010;  4'h9: enc = 5'b10011;
      4'hA: enc = 5'b10110;  4'hB: enc = 5'b10111;
      4'hC: enc = 5'b11010;  4'hD: enc = 5'b11011;
      4'hE: enc = 5'b11100;  default: enc = 5'b11101;
    endcase
  endfunction

  assign last = (bc == 3'd4);
  assign smp  = (bc == 3'd0) | (rmii_mode & (bc == 3'd3));
  assign key  = lf[10] ^ lf[8];
  assign sbit = sh[0] ^ key;
  assign line = lvl[0] ? (lvl[1] ? 2'sb11 : 2'sb01) : 2'sb00;

  always_comb begin
    st_n = st;
    nxt  = CG_IDLE;
    case (st)
      F_IDLE: if (en_s) begin nxt = CG_J; st_n = F_K; end
      F_K:    begin nxt = CG_K; st_n = F_DATA; end
      F_DATA: if (en_s) nxt = enc(nib);
              else begin nxt = CG_T; st_n = F_R; end
      default: begin nxt = CG_R; st_n = F_IDLE; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bc     <= '0;
      nib    <= '0;
      en_s   <= 1'b0;
      st     <= F_IDLE;
      sh     <= CG_IDLE;
      lf     <= SEED;
      nrzi_o <= 1'b0;
      lvl    <= '0;
    end else begin
      bc <= last ? 3'd0 : bc + 3'd1;
      if (bc == 3'd0) begin
        en_s <= tx_en;
        if (rmii_mode) nib[1:0] <= txd[1:0];
        else           nib      <= txd;
      end
      if (rmii_mode && bc == 3'd3) nib[3:2] <= txd[1:0];
      if (last) st <= st_n;
      sh     <= last ? nxt : {1'b0, sh[4:1]};
      lf     <= {lf[9:0], key};
      nrzi_o <= nrzi_o ^ sbit;
      lvl    <= lvl + {1'b0, sbit};
    end
  end
endmodule

// File: rtl/fetx_coder_chk.sv
module fetx_coder_chk (
  input logic              clk,
  input logic              rst_n,
  input logic              rmii_mode,
  input logic              smp,
  input logic              nrzi_o,
  input logic signed [1:0] line
);
  logic [2:0]        gap;
  logic signed [1:0] last_nz;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap     <= '0;
      last_nz <= 2'sb11;
    end else begin
      gap <= smp ? 3'd0 : gap + 3'd1;
      if (line != 2'sb00) last_nz <= line;
    end
  end

  // R2
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp |=> !smp);

  // R2
  strobe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp |-> (gap <= (rmii_mode ? 3'd1 : 3'd3)));

  // R8
  nrzi_tracks_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nrzi_o != $past(nrzi_o)) == (line != $past(line)));

  // R9
  back_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(line) != 2'sb00 && line != $past(line)) |-> line == 2'sb00);

  // R9
  alternate_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(line) == 2'sb00 && line != 2'sb00) |->
      line == ((last_nz == 2'sb01) ? 2'sb11 : 2'sb01));
endmodule

bind fetx_coder fetx_coder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rmii_mode(rmii_mode),
  .smp(smp), .nrzi_o(nrzi_o), .line(line)
);

// File: tb/sim_fetx_coder.sv
module sim_fetx_coder;
  logic clk = 1'b0, rst_n = 1'b0, rmii = 1'b0, tx_en = 1'b0;
  logic [3:0] txd = '0;
  logic smp, nrzi;
  logic signed [1:0] line;

  always #10 clk = ~clk;

  fetx_coder u0 (.clk(clk), .rst_n(rst_n), .rmii_mode(rmii), .tx_en(tx_en),
                 .txd(txd), .smp(smp), .nrzi_o(nrzi), .line(line));

  int vec = 0, bad = 0;
  int ph, fst, m_mlt, gb;
  bit s_en, m_nrzi, prev_n;
  bit [1:0] s_lo;
  bit [3:0] s_nib;
  bit [4:0] cur, got;
  bit [10:0] lf;
  bit keyq[$];
  bit [4:0] gq[$];
  string tq[$];

  function automatic bit [4:0] enc(input bit [3:0] n);
    bit [4:0] t[16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101, 5'b01010, 5'b01011,
                        5'b01110, 5'b01111, 5'b10010, 5'b10011, 5'b10110, 5'b10111,
                        5'b11010, 5'b11011, 5'b11100, 5'b11101};
    return t[n];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_reset(input bit mode);
    rmii = mode; rst_n = 1'b0; tx_en = 1'b0; txd = '0;
    repeat (3) @(negedge clk);
    ph = 0; fst = 0; cur = 5'b11111; lf = 11'h7FF; m_nrzi = 0; m_mlt = 0;
    s_en = 0; s_nib = 0; s_lo = 0; prev_n = 0; gb = 0;
    keyq.delete(); gq.delete(); tq.delete();
    gq.push_back(5'b11111); tq.push_back("R1/R7 first IDLE");
    chk(line == 2'sb00, "R1 line in reset", int'(line), 0);
    chk(nrzi == 1'b0, "R1 nrzi in reset", int'(nrzi), 0);
    rst_n = 1'b1;
  endtask

  task automatic step(input bit [3:0] d, input bit e);
    bit k, b;
    int el;
    txd = d; tx_en = e;
    #1;
    chk(smp == (ph == 0 || (rmii && ph == 3)), "R2 strobe", int'(smp),
        int'(ph == 0 || (rmii && ph == 3)));
    if (ph == 0) begin
      s_en = e;
      if (rmii) s_lo = d[1:0]; else s_nib = d;
    end
    if (rmii && ph == 3) s_nib = {d[1:0], s_lo};
    k = lf[10] ^ lf[8];
    b = cur[ph] ^ k;
    lf = {lf[9:0], k};
    keyq.push_back(k);
    m_nrzi ^= b;
    if (b) m_mlt = (m_mlt + 1) % 4;
    if (ph == 4) begin
      case (fst)
        0: if (s_en) begin cur = 5'b11000; fst = 1; tq.push_back("R5/R7 J"); end
           else begin cur = 5'b11111; tq.push_back("R6/R7 IDLE"); end
        1: begin cur = 5'b10001; fst = 2; tq.push_back("R5/R7 K"); end
        2: if (s_en) begin
             cur = enc(s_nib);
             tq.push_back(rmii ? "R3/R4/R7 data" : "R4/R7 data");
           end else begin cur = 5'b01101; fst = 3; tq.push_back("R6/R7 T"); end
        default: begin cur = 5'b00111; fst = 0; tq.push_back("R6/R7 R"); end
      endcase
      gq.push_back(cur);
    end
    ph = (ph + 1) % 5;
    @(negedge clk);
    el = (m_mlt == 1) ? 1 : (m_mlt == 3) ? -1 : 0;
    chk(int'(line) == el, "R9 level", int'(line), el);
    chk(nrzi == m_nrzi, "R8 nrzi", int'(nrzi), int'(m_nrzi));
    got[gb] = (nrzi ^ prev_n) ^ keyq.pop_front();
    prev_n = nrzi;
    gb++;
    if (gb == 5) begin
      bit [4:0] eg;
      string tg;
      eg = gq.pop_front();
      tg = tq.pop_front();
      chk(got == eg, tg, int'(got), int'(eg));
      gb = 0;
    end
  endtask

  task automatic send_nib(input bit [3:0] d, input bit e);
    if (!rmii) begin
      for (int i = 0; i < 5; i++) step(d, e);
    end else begin
      step({~d[3:2], d[1:0]}, e);
      step({2'b00, d[1:0]}, e);
      step({2'b00, d[1:0]}, e);
      step({d[1:0], d[3:2]}, e);
      step({2'b00, d[3:2]}, e);
    end
  endtask

  task automatic frame(input int n);
    for (int i = 0; i < n; i++) send_nib(4'($urandom), 1'b1);
  endtask

  task automatic gap(input int n);
    for (int i = 0; i < n; i++) send_nib(4'($urandom), 1'b0);
  endtask

  initial begin
    #(20 * 200000);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    model_reset(1'b0);
    gap(3); frame(1); gap(4); frame(2); gap(3); frame(20);
    gap(1); frame(6); gap(5);
    model_reset(1'b1);
    gap(2); frame(3); gap(3); frame(16); gap(1); frame(1);
    gap(1); frame(5); gap(6);
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule